// File: doc/BRIEF.md
# Serial Converter Sample Reader

This block is the host side of a four-wire link to a 10-bit successive-approximation converter with a serial port. When it gets a start pulse, it takes a channel number and two input-mode bits and builds a command byte. It then pulls chip select low and runs three 8-bit full-duplex transfers in clock-low / sample-on-rising mode. The first transfer sends the command and throws away what comes back. The other two send zeros and collect the 16 bits that hold the conversion. After the last transfer it releases chip select, pulses `done` for one cycle and presents the result.

The serial clock comes from the system clock. The half-period is a run-time value counted in system clocks, so a 250 MHz system clock can cover a serial clock range of roughly 100 kHz to 2 MHz. An optional pause in system clocks can be placed between bytes. A counter measures the whole transaction against a fixed limit, because the converter's hold capacitor droops if the readout takes too long. When the limit is exceeded, the result is flagged. The result can be returned zero-extended (unipolar input) or sign-extended (bipolar input, two's complement).

Top module: `adc_read_seq`

## Requirements
- R1: After reset and while idle: `cs_n`=1, `sclk`=0, `mosi`=0, `busy`=0, `done`=0.
- R2: The command byte is sent MSB first. Bit 7 is always 1. Bits 6:4 are `chan[2:0]`, bit 3 is `unipolar`, bit 2 is `single_ended`, and bits 1:0 are always 11.
- R3: `sclk` idles low. `mosi` changes only on a falling `sclk` edge or while `sclk` is low. `miso` is sampled on each rising `sclk` edge.
- R4: One transaction keeps `cs_n` low for exactly 24 rising `sclk` edges. The second and third bytes sent are 0x00.
- R5: The result field is bits 14:5 of the 16-bit word made from the second received byte (high half) and the third received byte (low half). The first received byte and all other bits of the word have no effect. With `unipolar`=1, `sample` is the field zero-extended to 16 bits.
- R6: With `unipolar`=0, `sample` is the field sign-extended from its bit 9.
- R7: `sclk` stays high for max(`half_div`,1) system clocks, and stays low for the same time within a byte.
- R8: Between bytes, `sclk` stays low for `dead` + max(`half_div`,1) system clocks, with `cs_n` still low.
- R9: `droop_err` is 1 with `done` when the transaction lasted more than `TIMEOUT_CYC` system clocks, and 0 otherwise.
- R10: `busy` is high from the accepted start until `done`. A `start` while busy is ignored: no second transaction, and the command byte is not changed.
- R11: `done` is a one-cycle pulse, and `cs_n` is already high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one read |
| chan | input | 3 | Channel select |
| unipolar | input | 1 | 1 = unipolar input / zero-extend, 0 = bipolar / sign-extend |
| single_ended | input | 1 | 1 = single-ended input, 0 = differential |
| half_div | input | HALF_W | Serial clock half-period in system clocks |
| dead | input | DEAD_W | Pause between bytes in system clocks |
| miso | input | 1 | Serial data from converter |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to converter |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Result valid pulse |
| sample | output | 16 | Extended 10-bit result |
| droop_err | output | 1 | Transaction exceeded time limit |

## Verification
Some properties are checked on every cycle:
- `mosi` holds steady while `sclk` is high.
- `sclk` stays low whenever chip select is released.
- `done` lasts exactly one cycle and comes with chip select high.
- The divider count stays below the half-period.
- The latched command holds for the whole transaction.
- The overrun flag is sticky.

Other behaviour only the bench scenarios can show, using a converter model that replies with known bit streams. These are the exact command bits, the bit position of the extracted field with junk in the sub-LSB and first-byte positions, sign extension, the measured high and gap lengths, the timeout verdict, and that a second start leaves no trace.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_t;

  localparam int BYTE_W   = 8;
  localparam int FIELD_W  = 10;
  localparam int FIELD_LO = 5;
  localparam int NBYTES   = 3;

  function automatic logic [BYTE_W-1:0] make_cmd(input logic [2:0] ch,
                                                 input logic       uni,
                                                 input logic       se);
    return {1'b1, ch, uni, se, 2'b11};
  endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_div,
  output logic              sclk,
  output logic              rise,
  output logic              fall
);
  logic [HALF_W-1:0] half_eff;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              sclk_d;
  logic              hit;

  assign half_eff = (half_div == '0) ? HALF_W'(1) : half_div;
  assign hit      = run && (cnt_q == half_eff - HALF_W'(1));
  assign rise     = hit && !sclk;
  assign fall     = hit && sclk;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (hit) begin
      cnt_d  = '0;
      sclk_d = !sclk;
    end else begin
      cnt_d  = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sclk  <= sclk_d;
    end
  end

  // R7: the divider count never reaches the half-period
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half_eff));

endmodule

// File: rtl/adc_byte_shifter.sv
module adc_byte_shifter #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_byte,
  input  logic          rise,
  input  logic          fall,
  input  logic          miso,
  input  logic          sclk,
  output logic          mosi,
  output logic [BW-1:0] rx_byte,
  output logic          byte_end
);
  localparam int CW = $clog2(BW);

  logic [BW-1:0] tx_q, tx_d, rx_d;
  logic [CW-1:0] bit_q, bit_d;

  assign byte_end = fall && (bit_q == CW'(BW-1));
  assign mosi     = tx_q[BW-1];

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_byte;
    bit_d = bit_q;
    if (rise) rx_d = {rx_byte[BW-2:0], miso};
    if (load) begin
      tx_d  = load_byte;
      bit_d = '0;
    end else if (byte_end) begin
      bit_d = '0;
    end else if (fall) begin
      tx_d  = {tx_q[BW-2:0], 1'b0};
      bit_d = bit_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_byte <= '0;
      bit_q   <= '0;
    end else begin
      tx_q    <= tx_d;
      rx_byte <= rx_d;
      bit_q   <= bit_d;
    end
  end

  // R3: data out is held while the serial clock stays high
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/adc_droop_timer.sv
module adc_droop_timer #(
  parameter int TIMEOUT_CYC = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic over
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1) + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          over_d;

  always_comb begin
    cnt_d  = cnt_q;
    over_d = over;
    if (clear) begin
      cnt_d  = '0;
      over_d = 1'b0;
    end else if (run && !over) begin
      if (cnt_q == CW'(TIMEOUT_CYC)) over_d = 1'b1;
      else                           cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      over  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      over  <= over_d;
    end
  end

  // R9: once raised, the overrun flag holds until the next start
  p_over_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (over && !clear) |=> over);

endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq #(
  parameter int HALF_W      = 16,
  parameter int DEAD_W      = 8,
  parameter int TIMEOUT_CYC = 30000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        chan,
  input  logic              unipolar,
  input  logic              single_ended,
  input  logic [HALF_W-1:0] half_div,
  input  logic [DEAD_W-1:0] dead,
  input  logic              miso,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [15:0]       sample,
  output logic              droop_err
);
  import adc_seq_pkg::*;

  seq_state_t        st_q, st_d;
  logic [1:0]        bidx_q, bidx_d;
  logic [DEAD_W-1:0] gap_q, gap_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  logic [BYTE_W-1:0] rb2_q, rb2_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic [DEAD_W-1:0] dead_q, dead_d;
  logic              uni_q, uni_d;
  logic              done_d, err_d;
  logic [15:0]       sample_d;

  logic              accept, finish, load;
  logic [BYTE_W-1:0] load_byte;
  logic              run, rise, fall, byte_end, over;
  logic [BYTE_W-1:0] rx_byte;
  logic [15:0]       word;
  logic [FIELD_W-1:0] field;

  assign busy   = (st_q != ST_IDLE);
  assign cs_n   = !busy;
  assign run    = (st_q == ST_XFER);
  assign accept = (st_q == ST_IDLE) && start;
  assign word   = {rb2_q, rx_byte};
  assign field  = word[FIELD_LO +: FIELD_W];

  adc_sclk_gen #(.HALF_W(HALF_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_q),
    .sclk(sclk), .rise(rise), .fall(fall)
  );

  adc_byte_shifter #(.BW(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte),
    .rise(rise), .fall(fall), .miso(miso), .sclk(sclk),
    .mosi(mosi), .rx_byte(rx_byte), .byte_end(byte_end)
  );

  adc_droop_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(busy), .over(over)
  );

  always_comb begin
    st_d      = st_q;
    bidx_d    = bidx_q;
    gap_d     = gap_q;
    cmd_d     = cmd_q;
    rb2_d     = rb2_q;
    half_d    = half_q;
    dead_d    = dead_q;
    uni_d     = uni_q;
    load      = 1'b0;
    load_byte = '0;
    finish    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          cmd_d     = make_cmd(chan, unipolar, single_ended);
          half_d    = half_div;
          dead_d    = dead;
          uni_d     = unipolar;
          bidx_d    = '0;
          load      = 1'b1;
          load_byte = make_cmd(chan, unipolar, single_ended);
          st_d      = ST_XFER;
        end
      end
      ST_XFER: begin
        if (byte_end) begin
          if (bidx_q == 2'(NBYTES-1)) begin
            finish = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            if (bidx_q == 2'd1) rb2_d = rx_byte;
            bidx_d = bidx_q + 2'd1;
            if (dead_q == '0) begin
              load = 1'b1;
            end else begin
              gap_d = dead_q - DEAD_W'(1);
              st_d  = ST_GAP;
            end
          end
        end
      end
      ST_GAP: begin
        if (gap_q == '0) begin
          load = 1'b1;
          st_d = ST_XFER;
        end else begin
          gap_d = gap_q - DEAD_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_d   = finish;
    sample_d = sample;
    err_d    = droop_err;
    if (accept) err_d = 1'b0;
    if (finish) begin
      sample_d = uni_q ? {6'd0, field} : {{6{field[FIELD_W-1]}}, field};
      err_d    = over;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bidx_q    <= '0;
      gap_q     <= '0;
      cmd_q     <= '0;
      rb2_q     <= '0;
      half_q    <= HALF_W'(1);
      dead_q    <= '0;
      uni_q     <= 1'b1;
      done      <= 1'b0;
      sample    <= '0;
      droop_err <= 1'b0;
    end else begin
      st_q      <= st_d;
      bidx_q    <= bidx_d;
      gap_q     <= gap_d;
      cmd_q     <= cmd_d;
      rb2_q     <= rb2_d;
      half_q    <= half_d;
      dead_q    <= dead_d;
      uni_q     <= uni_d;
      done      <= done_d;
      sample    <= sample_d;
      droop_err <= err_d;
    end
  end

  // R3: the serial clock is low whenever chip select is released
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R11: done lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11: chip select is already high when done shows
  p_done_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  // R10: the command latched at start holds through the transaction
  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q));
  // R4: never more than three bytes
  p_byte_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bidx_q <= 2'd2));

endmodule

// File: tb/adc_read_seq_test.sv
`timescale 1ns/1ps
module adc_read_seq_test;
  localparam int TMO = 300;

  logic        clk, rst_n, start, unipolar, single_ended, miso;
  logic [2:0]  chan;
  logic [15:0] half_div;
  logic [7:0]  dead;
  logic        sclk, cs_n, mosi, busy, done, droop_err;
  logic [15:0] sample;

  int checks = 0, errors = 0;
  logic [16:0] exp_q[$];
  logic [7:0]  cmd_q[$];
  logic [23:0] slave_word, slave_sh, mosi_sh;
  int rise_cnt = 0, cs_falls = 0, hcur = 0, lcur = 0, last_high = 0, max_low = 0;

  adc_read_seq #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .unipolar(unipolar),
    .single_ended(single_ended), .half_div(half_div), .dead(dead), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done),
    .sample(sample), .droop_err(droop_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // converter model: first bit out at chip select fall, next bits on falling sclk
  always @(negedge cs_n) begin
    slave_sh = slave_word;
    miso = slave_sh[23];
    rise_cnt = 0;
    cs_falls++;
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      slave_sh = {slave_sh[22:0], 1'b0};
      miso = slave_sh[23];
    end
  end

  // outgoing data monitor
  always @(posedge sclk) begin
    mosi_sh = {mosi_sh[22:0], mosi};
    rise_cnt++;
  end
  always @(posedge cs_n) begin
    if (rst_n) begin
      chk(rise_cnt == 24, "R4", "rising edges per transaction", rise_cnt, 24);
      if (cmd_q.size() != 0) begin
        logic [7:0] c;
        c = cmd_q.pop_front();
        chk(mosi_sh[23:16] == c, "R2", "command byte", mosi_sh[23:16], c);
      end
      chk(mosi_sh[15:0] == 16'h0, "R4", "fill bytes", mosi_sh[15:0], 0);
    end
  end

  // result monitor and clock-shape monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      chk(cs_n == 1'b1, "R11", "cs_n at done", cs_n, 1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected done", 1, 0);
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        chk(sample == e[16:1], "R5/R6", "sample", sample, e[16:1]);
        chk(droop_err == e[0], "R9", "droop_err", droop_err, e[0]);
      end
    end
    if (rst_n && done === 1'b1) begin
      @(negedge clk);
      chk(done == 1'b0, "R11", "done width", done, 0);
    end
  end
  always @(negedge clk) begin
    if (!cs_n) begin
      if (sclk) begin hcur++; lcur = 0; end
      else begin
        if (hcur != 0) last_high = hcur;
        hcur = 0;
        lcur++;
        if (lcur > max_low) max_low = lcur;
      end
    end else begin
      hcur = 0; lcur = 0;
    end
  end

  task automatic run_conv(input logic [2:0] ch, input logic uni, input logic se,
                          input logic [9:0] val, input logic [1:0] sub,
                          input logic [15:0] h, input logic [7:0] d,
                          input logic exp_err, input bit poke);
    logic [15:0] exp_s;
    int hh, falls0, n;
    hh = (h == 0) ? 1 : int'(h);
    exp_s = uni ? {6'd0, val} : {{6{val[9]}}, val};
    slave_word = {8'hFF, 1'b0, val, sub, 3'b000};
    exp_q.push_back({exp_s, exp_err});
    cmd_q.push_back({1'b1, ch, uni, se, 2'b11});
    @(negedge clk);
    chan = ch; unipolar = uni; single_ended = se; half_div = h; dead = d;
    max_low = 0; last_high = 0;
    falls0 = cs_falls;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      chan = ~ch; unipolar = ~uni; half_div = h + 16'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    repeat (60) @(negedge clk);
    chk(cs_falls == falls0 + 1, "R10", "transactions per start", cs_falls - falls0, 1);
    chk(busy == 1'b0 && cs_n == 1'b1, "R1", "idle after done", {busy, cs_n}, 1);
    chk(last_high == hh, "R7", "sclk high length", last_high, hh);
    if (d != 0)
      chk(max_low == hh + int'(d), "R8", "inter-byte low length", max_low, hh + int'(d));
    else
      chk(max_low == hh, "R7", "sclk low length", max_low, hh);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; chan = 3'd0; unipolar = 1'b1; single_ended = 1'b1;
    half_div = 16'd2; dead = 8'd0; miso = 1'b0; slave_word = '0; mosi_sh = '0;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "cs_n/sclk in reset", {cs_n, sclk}, 2);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mosi == 1'b0 && cs_n == 1'b1, "R1", "mosi/cs_n idle", {mosi, cs_n}, 1);

    // R5: unipolar, sub-LSB ones must not leak into the field
    run_conv(3'd5, 1'b1, 1'b1, 10'h2A5, 2'b11, 16'd2, 8'd0, 1'b0, 0);
    // R5 with all ones field, R8 pause
    run_conv(3'd0, 1'b1, 1'b0, 10'h3FF, 2'b01, 16'd2, 8'd3, 1'b0, 0);
    // R6: bipolar negative and positive
    run_conv(3'd7, 1'b0, 1'b0, 10'h200, 2'b10, 16'd2, 8'd0, 1'b0, 0);
    run_conv(3'd2, 1'b0, 1'b1, 10'h1FF, 2'b00, 16'd2, 8'd0, 1'b0, 0);
    // R7: slower clock and half_div of zero
    run_conv(3'd3, 1'b1, 1'b1, 10'h155, 2'b00, 16'd5, 8'd3, 1'b0, 0);
    run_conv(3'd6, 1'b1, 1'b1, 10'h0AA, 2'b11, 16'd0, 8'd1, 1'b0, 0);
    // R10: start while busy ignored
    run_conv(3'd1, 1'b1, 1'b1, 10'h123, 2'b01, 16'd2, 8'd0, 1'b0, 1);
    // R9: overruns by long pause and by slow clock, then a clean one again
    run_conv(3'd4, 1'b1, 1'b1, 10'h321, 2'b00, 16'd2, 8'd150, 1'b1, 0);
    run_conv(3'd4, 1'b0, 1'b1, 10'h080, 2'b00, 16'd8, 8'd0, 1'b1, 0);
    run_conv(3'd4, 1'b1, 1'b1, 10'h001, 2'b00, 16'd2, 8'd0, 1'b0, 0);

    chk(exp_q.size() == 0, "R11", "results outstanding", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule